// File: doc/BRIEF.md
# Programmable Wait State Inserter

This block stretches accesses to one slow peripheral by holding the processor's ready input low for a chosen number of clock periods. It watches three signals: the chip select of the designated device, the active-high access strobe (the read or write command), and a marker that is high during the first clock of every bus cycle. A static 3-bit select input, wired like a jumper, picks between zero and seven wait states. The output drives the ready-synchronizer input that feeds the bus cycle sequencer.

Internally a chain of seven flip-flops fills with ones, one stage per clock, while an access to the designated device is in progress. The chain is emptied in the first clock of each bus cycle and whenever no designated access is active. A stage of the chain is picked by the select value; the stage ORed with the inactive strobe forms the ready output. A select value of zero picks a constant one, so no wait is inserted.

Top module: `wait_state_gen`

## Requirements
- R1: While `rst_ni` is low, `ready_o` is 1 whatever the other inputs are, and the chain is empty, so an access already active when reset is released still gets its full `wait_sel_i` wait cycles.
- R2: When the access is not active (`dev_cs_i` low or `strobe_i` low), `ready_o` is 1 in that same cycle.
- R3: With `wait_sel_i` = 0, `ready_o` is 1 in every cycle of a designated access.
- R4: With `wait_sel_i` = N (1 to 7), `ready_o` is 0 in the first N cycles in which the designated access is active and 1 from cycle N+1 on.
- R5: Once `ready_o` is 1 in an access, it stays 1 until the access ends, as long as `wait_sel_i` is unchanged and no first-cycle marker arrives.
- R6: A cycle with `t1_i` high empties the chain at the following clock edge, even during an active access, so the count restarts from zero.
- R7: A single idle cycle between two designated accesses is enough for the second one to receive the full N wait cycles again.
- R8: A strobe aimed at another device (`dev_cs_i` low) inserts no wait cycles for any select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_sel_i | input | 3 | Static wait count, 0 to 7 |
| dev_cs_i | input | 1 | Chip select of the designated slow device |
| strobe_i | input | 1 | Access command, high while the read or write strobe is active |
| t1_i | input | 1 | High during the first clock of a bus cycle |
| ready_o | output | 1 | Ready to the synchronizer, 0 inserts a wait state |

## Verification
The first-cycle clear and the advance of the chain can both be due at the same edge while an access is active; the bench raises `t1_i` in the middle of a designated access with the strobe still high and expects the clear to win, so the low stretch restarts and lasts the full count again after the marker. Reset release and an already active access also meet at one edge: the bench holds an access through reset and expects the first full count of low cycles to begin only after release.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  parameter int unsigned SEL_W = 3;

  function automatic int unsigned chain_depth(int unsigned sel_w);
    return (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/wsg_fill_chain.sv
module wsg_fill_chain #(
  parameter int unsigned DEPTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [DEPTH-1:0] q_o
);
  logic [DEPTH:0] d;
  assign d[0] = 1'b1;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o[k] <= 1'b0;
      else if (clr_i) q_o[k] <= 1'b0;
      else if (adv_i) q_o[k] <= d[k];
    end
    assign d[k+1] = q_o[k];
  end
endmodule

// File: rtl/wsg_tap_pick.sv
module wsg_tap_pick #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned DEPTH = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DEPTH-1:0] taps_i,
  output logic             tap_o
);
  // position 0 is a constant one: zero waits
  logic [DEPTH:0] ext;
  assign ext   = {taps_i, 1'b1};
  assign tap_o = ext[sel_i];
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
  import wsg_pkg::*;
#(
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] wait_sel_i,
  input  logic          dev_cs_i,
  input  logic          strobe_i,
  input  logic          t1_i,
  output logic          ready_o
);
  localparam int unsigned DEPTH = chain_depth(SW);

  logic             access;
  logic [DEPTH-1:0] taps;
  logic             tap;

  assign access = dev_cs_i & strobe_i;

  wsg_fill_chain #(.DEPTH(DEPTH)) i_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (t1_i | ~access),
    .adv_i  (access),
    .q_o    (taps)
  );

  wsg_tap_pick #(.SEL_W(SW)) i_pick (
    .sel_i  (wait_sel_i),
    .taps_i (taps),
    .tap_o  (tap)
  );

  assign ready_o = ~rst_ni | ~access | tap;
endmodule

// File: rtl/wsg_chk.sv
module wsg_chk #(
  parameter int unsigned SW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [SW-1:0] wait_sel_i,
  input logic          dev_cs_i,
  input logic          strobe_i,
  input logic          t1_i,
  input logic          ready_o
);
  logic acc;
  assign acc = dev_cs_i & strobe_i;

  // R2
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |-> ready_o);

  // R8
  other_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !dev_cs_i) |-> ready_o);

  // R3
  zero_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_sel_i == '0) |-> ready_o);

  // R4
  first_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(acc) && wait_sel_i != '0) |-> !ready_o);

  // R5
  hold_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ready_o && !t1_i) |=> (!acc || ready_o || !$stable(wait_sel_i)));
endmodule

bind wait_state_gen wsg_chk #(.SW(SW)) i_wsg_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wait_sel_i (wait_sel_i),
  .dev_cs_i   (dev_cs_i),
  .strobe_i   (strobe_i),
  .t1_i       (t1_i),
  .ready_o    (ready_o)
);

// File: tb/test_wait_state_gen.sv
module test_wait_state_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] wait_sel_i = '0;
  logic       dev_cs_i = 1'b0;
  logic       strobe_i = 1'b0;
  logic       t1_i = 1'b0;
  logic       ready_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  wait_state_gen i_wait_state_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .wait_sel_i(wait_sel_i),
    .dev_cs_i(dev_cs_i), .strobe_i(strobe_i), .t1_i(t1_i), .ready_o(ready_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ready_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, sample 1 ns later
  task automatic step;
    @(negedge clk_i);
  endtask

  task automatic idle_cycle;
    step(); dev_cs_i = 1'b0; strobe_i = 1'b0; t1_i = 1'b0;
    #1 check("R2", ready_o, 1'b1);
  endtask

  task automatic run_access(input int n, input int len, input string req);
    wait_sel_i = 3'(n);
    for (int c = 0; c < len; c++) begin
      step(); dev_cs_i = 1'b1; strobe_i = 1'b1; t1_i = 1'b0;
      #1 check(req, ready_o, (c >= n) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic test_reset;
    wait_sel_i = 3'd3; dev_cs_i = 1'b1; strobe_i = 1'b1;
    step(); #1 check("R1", ready_o, 1'b1);
    step(); #1 check("R1", ready_o, 1'b1);
    rst_ni = 1'b1;
    #1 check("R1", ready_o, 1'b0);
    for (int c = 1; c < 6; c++) begin
      step(); #1 check("R1", ready_o, (c >= 3) ? 1'b1 : 1'b0);
    end
    idle_cycle();
  endtask

  task automatic test_idle;
    for (int s = 0; s < 8; s++) begin
      wait_sel_i = 3'(s);
      step(); dev_cs_i = 1'b1; strobe_i = 1'b0;
      #1 check("R2", ready_o, 1'b1);
    end
    idle_cycle();
  endtask

  task automatic test_other_dev;
    for (int s = 0; s < 8; s++) begin
      wait_sel_i = 3'(s);
      step(); dev_cs_i = 1'b0; strobe_i = 1'b1;
      #1 check("R8", ready_o, 1'b1);
    end
    idle_cycle();
  endtask

  task automatic test_all_counts;
    run_access(0, 4, "R3");
    idle_cycle();
    for (int s = 1; s < 8; s++) begin
      run_access(s, s + 3, "R4/R5");
      idle_cycle();
    end
  endtask

  task automatic test_back_to_back;
    run_access(2, 4, "R7");
    idle_cycle();
    run_access(2, 4, "R7");
    idle_cycle();
  endtask

  task automatic test_t1_restart;
    wait_sel_i = 3'd4;
    for (int c = 0; c < 10; c++) begin
      step(); dev_cs_i = 1'b1; strobe_i = 1'b1; t1_i = (c == 2);
      #1 check("R6", ready_o, (c >= 7) ? 1'b1 : 1'b0);
    end
    idle_cycle();
  endtask

  initial begin
    test_reset();
    test_idle();
    test_other_dev();
    test_all_counts();
    test_back_to_back();
    test_t1_restart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: ready_o=%0b expected completion", ready_o);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule